// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block turns parallel characters into asynchronous NRZ frames on one output line. A write port fills a waiting register. When the shift stage is free and transmission is enabled, the waiting character moves into the shift stage. This leaves the waiting register open for the next character while the current one is still going out, so a steady stream of characters can be sent with no idle time between frames.

Bit timing comes from outside the block. A one-cycle `bit_tick` pulse marks each bit period, and the block moves forward by exactly one bit per pulse. A mode input selects 8-bit or 9-bit characters. In 9-bit mode the extra bit comes from a separate input. A break request replaces data frames with frames that are zero for their whole length. Two flags report whether the waiting register is free and whether all sending has finished.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset `tx_line` is 1, `dr_empty` is 1 and `tx_done` is 1. While no frame is in progress, `tx_line` stays at 1.
- R2: A data frame is one start bit at 0, then the data bits with bit 0 first, then one stop bit at 1. Each bit lasts from one `bit_tick` to the next.
- R3: The character width is chosen when the character moves into the shift stage. If `nine_bit_mode` is 0 there are 8 data bits, taken from `wr_data[7:0]`. If it is 1 there are 9 data bits, and the last one is the value of `ninth_bit` sampled in that same cycle. Changing either input after the transfer does not affect that frame.
- R4: A character moves from the waiting register to the shift stage only on a `bit_tick` where two things hold: the shift stage is idle or in the last tick of its stop bit, and `tx_en` is 1. The start bit of the new frame begins at that tick. A character that is already waiting therefore follows the previous frame with no idle bit in between.
- R5: A character can be written while another frame is shifting out. It waits and is sent next, in write order. A write to a waiting register that is still full replaces the waiting character, and the replaced character is never sent.
- R6: `dr_empty` goes to 0 in the cycle after a write. It goes to 1 in the cycle after the transfer to the shift stage, unless a write happens in that same cycle.
- R7: `tx_done` goes to 0 when a frame starts. It goes to 1 at the end of a stop bit, or at the end of a break frame, when no new frame starts at that tick.
- R8: While `tx_en` is 0, no new frame starts and a waiting character stays waiting. A frame that is already in progress when `tx_en` drops finishes completely, and then the line returns to 1.
- R9: If `brk_req` and `tx_en` are both 1 at a frame boundary, a break frame is sent: the line is 0 for the full length of a frame in the current mode. Break frames repeat for as long as the request is held. A break takes priority over a waiting character.
- R10: `tx_line` only changes in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| tx_en | input | 1 | Allows new frames to start |
| nine_bit_mode | input | 1 | 0 selects 8-bit characters, 1 selects 9-bit characters |
| ninth_bit | input | 1 | Value of the ninth data bit in 9-bit mode |
| brk_req | input | 1 | Requests break frames |
| wr_en | input | 1 | Writes `wr_data` into the waiting register |
| wr_data | input | DATA_W | Character to send |
| tx_line | output | 1 | Serial output line |
| dr_empty | output | 1 | 1 when the waiting register can accept a character |
| tx_done | output | 1 | 1 when nothing is being sent |

## Verification
The bench builds the block with the default `DATA_W` of 8 and pulses `bit_tick` every fourth clock. At that rate the bench has a few clock cycles inside each bit period, so it can write a new character, or drop `tx_en` or `brk_req`, in the middle of a frame. With 8 data bits the bench can also check the full frame length in both modes: 10 ticks in 8-bit mode and 11 ticks in 9-bit mode, and the same lengths for break frames. A decoder in the bench samples the line once per tick and compares each frame against a queue of expected characters, which also checks the order of the frames and that no idle bit appears between back-to-back frames.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DATA  = 2'd1,
    SEQ_BREAK = 2'd2
  } seq_state_e;

  // Position of the stop bit inside a frame: start at 0, data from 1.
  function automatic int unsigned stop_index(input int unsigned data_w, input logic nine);
    return data_w + 1 + 32'(nine);
  endfunction

  // Level on the line for a given sequencer state and frame position.
  function automatic logic line_level(input seq_state_e st, input logic at_start,
                                      input logic at_stop, input logic lsb);
    logic lvl;
    case (st)
      SEQ_IDLE:  lvl = 1'b1;
      SEQ_BREAK: lvl = 1'b0;
      default:   lvl = at_start ? 1'b0 : (at_stop ? 1'b1 : lsb);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import uart_dbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              frame_end,
  output logic              line_out,
  output logic              done
);

  localparam int CHAR_W = DATA_W + 1;
  localparam int POS_W  = $clog2(DATA_W + 3);

  seq_state_e        state_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  last_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              done_q;

  logic             boundary;
  logic             start_brk;
  logic [POS_W-1:0] new_last;

  assign new_last  = POS_W'(stop_index(DATA_W, nine_bit_mode));
  assign frame_end = bit_tick && (state_q != SEQ_IDLE) && (pos_q == last_q);
  assign boundary  = bit_tick && ((state_q == SEQ_IDLE) || (pos_q == last_q));
  assign start_brk = boundary && tx_en && brk_req;
  assign take      = boundary && tx_en && !brk_req && hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pos_q   <= '0;
      last_q  <= '0;
      shreg_q <= '0;
      done_q  <= 1'b1;
    end else if (take) begin
      state_q <= SEQ_DATA;
      pos_q   <= '0;
      last_q  <= new_last;
      shreg_q <= {ninth_bit & nine_bit_mode, hold_data};
      done_q  <= 1'b0;
    end else if (start_brk) begin
      state_q <= SEQ_BREAK;
      pos_q   <= '0;
      last_q  <= new_last;
      done_q  <= 1'b0;
    end else if (frame_end) begin
      state_q <= SEQ_IDLE;
      pos_q   <= '0;
      done_q  <= 1'b1;
    end else if (bit_tick && state_q != SEQ_IDLE) begin
      pos_q <= pos_q + 1'b1;
      if (state_q == SEQ_DATA && pos_q != '0) shreg_q <= shreg_q >> 1;
    end
  end

  assign line_out = line_level(state_q, pos_q == '0, pos_q == last_q, shreg_q[0]);
  assign done     = done_q;

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              brk_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              dr_empty,
  output logic              tx_done
);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              load_pulse;
  logic              frame_end;

  tx_hold_reg #(.DATA_W(DATA_W)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .take     (load_pulse),
    .hold_data(hold_data),
    .hold_full(hold_full)
  );

  tx_frame_seq #(.DATA_W(DATA_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .tx_en        (tx_en),
    .brk_req      (brk_req),
    .nine_bit_mode(nine_bit_mode),
    .ninth_bit    (ninth_bit),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .take         (load_pulse),
    .frame_end    (frame_end),
    .line_out     (tx_line),
    .done         (tx_done)
  );

  assign dr_empty = !hold_full;

endmodule

// File: rtl/uart_dbtx_chk.sv
module uart_dbtx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_en,
  input logic tx_line,
  input logic dr_empty,
  input logic tx_done,
  input logic load_pulse,
  input logic frame_end
);

  a_r1_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_line);

  a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line));

  a_r4_load_on_tick_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> (bit_tick && !dr_empty));

  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dr_empty);

  a_r6_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !wr_en) |=> dr_empty);

  a_r7_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !tx_done);

  a_r7_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(frame_end));

endmodule

bind uart_dbuf_tx uart_dbtx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .wr_en     (wr_en),
  .tx_line   (tx_line),
  .dr_empty  (dr_empty),
  .tx_done   (tx_done),
  .load_pulse(load_pulse),
  .frame_end (frame_end)
);

// File: tb/uart_dbuf_tx_tb_top.sv
module uart_dbuf_tx_tb_top;
  localparam int DW       = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          tx_en = 1'b0;
  logic          nine_bit_mode = 1'b0;
  logic          ninth_bit = 1'b0;
  logic          brk_req = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          tx_line, dr_empty, tx_done;

  uart_dbuf_tx #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .nine_bit_mode(nine_bit_mode), .ninth_bit(ninth_bit), .brk_req(brk_req),
    .wr_en(wr_en), .wr_data(wr_data), .tx_line(tx_line), .dr_empty(dr_empty),
    .tx_done(tx_done)
  );

  typedef struct {
    logic [DW:0] d;
    logic        nine;
    logic        brk;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0;
  int   fails = 0;
  bit   in_frame = 0;
  int   idx = 0;
  int   tickno = 0;
  int   end_tick = -100;
  int   last_gap = 0;
  int   divcnt = 0;
  int   cyc = 0;
  logic [DW+2:0] got;

  function automatic int frame_bits(input logic nine);
    return DW + 2 + (nine ? 1 : 0);
  endfunction

  function automatic logic exp_bit(input exp_t e, input int i);
    if (e.brk || i == 0) return 1'b0;
    if (i == frame_bits(e.nine) - 1) return 1'b1;
    return e.d[i-1];
  endfunction

  function automatic logic [DW+2:0] exp_vec(input exp_t e);
    logic [DW+2:0] v = '0;
    for (int i = 0; i < frame_bits(e.nine); i++) v[i] = exp_bit(e, i);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Tick generation, frame decoder and watchdog
  always @(negedge clk) begin
    automatic bit seen = bit_tick;
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (seen && rst_n) begin
      tickno++;
      if (!in_frame) begin
        if (tx_line == 1'b0) begin
          if (q.size() == 0) begin
            check(0, "R8 unexpected frame start", 0, 1);
          end else begin
            cur = q.pop_front();
            got = '0;
            idx = 1;
            in_frame = 1;
            last_gap = tickno - end_tick;
          end
        end
      end else begin
        got[idx] = tx_line;
        idx++;
        if (idx == frame_bits(cur.nine)) begin
          // R2 frame format, R3 nine-bit frames, R9 break frames
          check(got == exp_vec(cur),
                cur.brk ? "R9 break frame" : (cur.nine ? "R3 nine-bit frame" : "R2 frame"),
                int'(got), int'(exp_vec(cur)));
          in_frame = 0;
          end_tick = tickno;
        end
      end
    end
    if (divcnt == TICK_DIV - 1) begin
      divcnt = 0;
      bit_tick = 1'b1;
    end else begin
      divcnt++;
      bit_tick = 1'b0;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_char(input logic [DW-1:0] d, input logic nine, input logic b9, input bit expect_it);
    exp_t e;
    @(negedge clk);
    nine_bit_mode = nine;
    ninth_bit = b9;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (expect_it) begin
      e.d = {nine & b9, d};
      e.nine = nine;
      e.brk = 1'b0;
      q.push_back(e);
    end
  endtask

  task automatic wait_empty();
    int n = 0;
    while (dr_empty !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check(0, "R4 transfer timeout", 0, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!(q.size() == 0 && !in_frame && tx_done === 1'b1 && dr_empty === 1'b1) && n < 5000) begin
      @(negedge clk); n++;
    end
    if (n >= 5000) check(0, "R7 idle timeout", q.size(), 0);
  endtask

  initial begin
    exp_t be;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_line == 1'b1, "R1 line after reset", tx_line, 1);
    check(dr_empty == 1'b1, "R1 dr_empty after reset", dr_empty, 1);
    check(tx_done == 1'b1, "R1 tx_done after reset", tx_done, 1);

    // Single 8-bit character
    tx_en = 1'b1;
    put_char(8'hA5, 1'b0, 1'b0, 1);
    check(dr_empty == 1'b0, "R6 write clears dr_empty", dr_empty, 0);
    wait_empty();
    @(negedge clk);
    check(tx_done == 1'b0, "R7 tx_done low during frame", tx_done, 0);
    wait_idle();
    check(tx_done == 1'b1 && tx_line == 1'b1, "R7 done and idle high", {tx_done, tx_line}, 3);

    // Back-to-back: second write while first shifts
    put_char(8'h3C, 1'b0, 1'b0, 1);
    wait_empty();
    put_char(8'hC3, 1'b0, 1'b0, 1);
    check(dr_empty == 1'b0, "R5 second char waits", dr_empty, 0);
    wait_idle();
    check(last_gap == 1, "R4 no idle bit between frames", last_gap, 1);

    // Nine-bit mode; inputs changed after transfer must not matter
    put_char(8'h5A, 1'b1, 1'b1, 1);
    wait_empty();
    nine_bit_mode = 1'b0;
    ninth_bit = 1'b0;
    wait_idle();
    put_char(8'h0F, 1'b1, 1'b0, 1);
    wait_idle();

    // Transmit disabled holds the waiting character
    tx_en = 1'b0;
    put_char(8'h11, 1'b0, 1'b0, 1);
    cycles(40);
    check(dr_empty == 1'b0, "R8 char held while disabled", dr_empty, 0);
    check(tx_line == 1'b1, "R8 line idle while disabled", tx_line, 1);
    tx_en = 1'b1;
    wait_idle();

    // Disable mid-frame: the frame completes
    put_char(8'h99, 1'b0, 1'b0, 1);
    wait_empty();
    cycles(10);
    tx_en = 1'b0;
    wait_idle();
    check(tx_line == 1'b1, "R8 line high after finished frame", tx_line, 1);
    tx_en = 1'b1;

    // Overwrite of a waiting character
    tx_en = 1'b0;
    put_char(8'h12, 1'b0, 1'b0, 0);
    put_char(8'h34, 1'b0, 1'b0, 1);
    tx_en = 1'b1;
    wait_idle();

    // Break takes priority over waiting data
    tx_en = 1'b0;
    be.d = '0; be.nine = 1'b0; be.brk = 1'b1;
    q.push_back(be);
    put_char(8'h77, 1'b0, 1'b0, 1);
    brk_req = 1'b1;
    tx_en = 1'b1;
    begin
      int n = 0;
      while (!(in_frame && cur.brk) && n < 500) begin @(negedge clk); n++; end
      check(n < 500, "R9 break started", n, 0);
    end
    brk_req = 1'b0;
    wait_idle();

    // Two break frames in 9-bit mode while held
    be.nine = 1'b1;
    q.push_back(be);
    q.push_back(be);
    nine_bit_mode = 1'b1;
    brk_req = 1'b1;
    begin
      int n = 0;
      while (q.size() != 0 && n < 500) begin @(negedge clk); n++; end
    end
    brk_req = 1'b0;
    wait_idle();

    // Random stream
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      wait_empty();
      cycles($urandom_range(0, 30));
      put_char(DW'($urandom()), 1'($urandom()), 1'($urandom()), 1);
    end
    wait_idle();
    check(q.size() == 0, "R5 all random chars sent", q.size(), 0);
    finish_run();
  end

endmodule